// File: doc/BRIEF.md
# Status Register Write Controller

This block keeps the current processor status word and one saved status word for each privileged bank. It applies move-to-status writes under control of four field-select bits and of the privilege of the current mode. A write strobe carries those field bits, a data word and a target select that chooses the current word or the saved word of the current bank. A separate mode-query input is translated into a bank index and selects which saved word appears on the read port.

The current word drives the individual condition-flag outputs, the two interrupt-mask outputs and a user/privileged translation output. When a write to the current word changes its mode field, the block raises a one-cycle pulse and presents the bank indices before and after the change. A narrow-program input, when low, confines the current word to its flag, interrupt-mask and two low mode bits.

Top module: `psr_ctrl`

## Requirements
- R1: After reset, status_o is 32'h0000_00D3 (supervisor mode 5'b10011, both interrupt masks set, flags clear), and mode_chg_o is low.
- R2: When the current mode maps to the user bank, a current-word write changes only bits 31:28, and only when wr_fields_i[3] is set. Bits 27:0 are never changed.
- R3: In any non-user bank, a current-word write with wr_fields_i equal to 4'b1001 replaces the whole word with wr_data_i.
- R4: In a non-user bank with any other field pattern, wr_fields_i[0] set writes bits 7:6 and 4:0 only. Otherwise wr_fields_i[3] set writes bits 31:28 only. With neither bit set, the word is left unchanged.
- R5: query_bank_o maps a mode number to a bank: 0 and 16 give 0 (user), 1 and 17 give 1 (fast interrupt), 2 and 18 give 2 (interrupt), 3 and 19 give 3 (supervisor), 23 gives 4 (abort) and 27 gives 5 (undefined). Every other value gives 6 (invalid).
- R6: A saved-word write while the current bank is 0 or 6 changes no stored word. saved_o returns status_o when the query bank is 0 or 6.
- R7: A saved-word write in banks 1 to 5 updates only that bank's saved word, with the field rules of R3 and R4. status_o does not change. saved_o shows the word of the queried bank.
- R8: While prog32_i is low, each current-word write leaves the result ANDed with 32'hF000_00C3.
- R9: priv_xlat_o is high exactly when status_o[1:0] is nonzero.
- R10: flag_n_o, flag_z_o, flag_c_o and flag_v_o follow status_o bits 31, 30, 29 and 28. irq_mask_o follows bit 7 and fiq_mask_o follows bit 6.
- R11: mode_chg_o is high for the single cycle after a current-word write that changes bits 4:0. During that cycle, old_bank_o and new_bank_o give the banks of the previous and the new mode.
- R12: In a cycle without wr_en_i, status_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog32_i | input | 1 | Wide program mode; low confines the current word |
| wr_en_i | input | 1 | Write strobe |
| wr_saved_i | input | 1 | Target select: 1 saved word of current bank, 0 current word |
| wr_fields_i | input | 4 | Field-select bits (bit 3 flags, bit 0 control) |
| wr_data_i | input | 32 | Write data |
| query_mode_i | input | 5 | Mode number to translate and read saved word for |
| status_o | output | 32 | Current status word |
| saved_o | output | 32 | Saved word of queried bank, or current word |
| query_bank_o | output | 3 | Bank index of query_mode_i |
| priv_xlat_o | output | 1 | Translation output, high outside mode bits 1:0 == 0 |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| irq_mask_o | output | 1 | Interrupt mask |
| fiq_mask_o | output | 1 | Fast interrupt mask |
| mode_chg_o | output | 1 | One-cycle pulse on mode change |
| old_bank_o | output | 3 | Bank before the change |
| new_bank_o | output | 3 | Bank after the change |

## Verification
The assertions assume that every input is stable and known at each rising clock edge, and that the user bank is recognised only from mode values 0 and 16. The user-mode property reads the mode straight from status_o. The bench changes inputs only on falling edges. It holds prog32_i constant between writes, and it leaves user mode only through reset, so that every stretch of stimulus starts from a known status word.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned MODE_W  = 5;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned BANK_W  = 3;
  localparam int unsigned N_SAVED = 5;

  typedef enum logic [BANK_W-1:0] {
    BANK_USR  = 3'd0,
    BANK_FIQ  = 3'd1,
    BANK_IRQ  = 3'd2,
    BANK_SVC  = 3'd3,
    BANK_ABT  = 3'd4,
    BANK_UND  = 3'd5,
    BANK_NONE = 3'd6
  } bank_e;

  localparam logic [WORD_W-1:0] FLAG_MASK   = 32'hF000_0000;
  localparam logic [WORD_W-1:0] CTRL_MASK   = 32'h0000_00DF;
  localparam logic [WORD_W-1:0] FULL_MASK   = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] NARROW_MASK = 32'hF000_00C3;
  localparam logic [WORD_W-1:0] RESET_WORD  = 32'h0000_00D3;

  localparam logic [FIELD_W-1:0] FIELDS_ALL = 4'b1001;
  localparam int unsigned FLD_CTRL = 0;
  localparam int unsigned FLD_FLAG = 3;

  localparam int unsigned BIT_N = 31;
  localparam int unsigned BIT_Z = 30;
  localparam int unsigned BIT_C = 29;
  localparam int unsigned BIT_V = 28;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
endpackage

// File: rtl/psr_bank_map.sv
module psr_bank_map
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  always_comb begin
    case (mode_i)
      5'd0,  5'd16: bank_o = BANK_USR;
      5'd1,  5'd17: bank_o = BANK_FIQ;
      5'd2,  5'd18: bank_o = BANK_IRQ;
      5'd3,  5'd19: bank_o = BANK_SVC;
      5'd23:        bank_o = BANK_ABT;
      5'd27:        bank_o = BANK_UND;
      default:      bank_o = BANK_NONE;
    endcase
  end
endmodule

// File: rtl/psr_field_mask.sv
module psr_field_mask
  import psr_pkg::*;
(
  input  logic               user_i,
  input  logic [FIELD_W-1:0] fields_i,
  output logic [WORD_W-1:0]  mask_o
);
  always_comb begin
    mask_o = '0;
    if (user_i) begin
      if (fields_i[FLD_FLAG]) mask_o = FLAG_MASK;
    end else if (fields_i == FIELDS_ALL) begin
      mask_o = FULL_MASK;
    end else if (fields_i[FLD_CTRL]) begin
      mask_o = CTRL_MASK;
    end else if (fields_i[FLD_FLAG]) begin
      mask_o = FLAG_MASK;
    end
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int unsigned DEPTH = N_SAVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  bank_e             wr_bank_i,
  input  logic [WORD_W-1:0] wr_mask_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  bank_e             rd_bank_i,
  input  logic [WORD_W-1:0] rd_fallback_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][WORD_W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en_i && (wr_bank_i == BANK_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= (word_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
    assign words[g] = word_q;
  end

  always_comb begin
    rd_data_o = rd_fallback_i;
    for (int i = 0; i < DEPTH; i++)
      if (rd_bank_i == BANK_W'(i + 1)) rd_data_o = words[i];
  end
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog32_i,
  input  logic               wr_en_i,
  input  logic               wr_saved_i,
  input  logic [FIELD_W-1:0] wr_fields_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [MODE_W-1:0]  query_mode_i,
  output logic [WORD_W-1:0]  status_o,
  output logic [WORD_W-1:0]  saved_o,
  output logic [BANK_W-1:0]  query_bank_o,
  output logic               priv_xlat_o,
  output logic               flag_n_o,
  output logic               flag_z_o,
  output logic               flag_c_o,
  output logic               flag_v_o,
  output logic               irq_mask_o,
  output logic               fiq_mask_o,
  output logic               mode_chg_o,
  output logic [BANK_W-1:0]  old_bank_o,
  output logic [BANK_W-1:0]  new_bank_o
);
  logic [WORD_W-1:0] cpsr_q, cpsr_merge, cpsr_next;
  logic [WORD_W-1:0] cur_mask, saved_mask;
  bank_e             cur_bank, next_bank, qry_bank;
  bank_e             old_bank_q, new_bank_q;
  logic              chg_q, cpsr_wr, saved_wr;

  psr_bank_map u_map_cur  (.mode_i(cpsr_q[MODE_W-1:0]),    .bank_o(cur_bank));
  psr_bank_map u_map_next (.mode_i(cpsr_next[MODE_W-1:0]), .bank_o(next_bank));
  psr_bank_map u_map_qry  (.mode_i(query_mode_i),          .bank_o(qry_bank));

  psr_field_mask u_mask_cur (
    .user_i  (cur_bank == BANK_USR),
    .fields_i(wr_fields_i),
    .mask_o  (cur_mask)
  );
  // saved words only exist in privileged banks, so no user restriction
  psr_field_mask u_mask_saved (
    .user_i  (1'b0),
    .fields_i(wr_fields_i),
    .mask_o  (saved_mask)
  );

  assign cpsr_wr    = wr_en_i && !wr_saved_i;
  assign saved_wr   = wr_en_i && wr_saved_i;
  assign cpsr_merge = (cpsr_q & ~cur_mask) | (wr_data_i & cur_mask);
  assign cpsr_next  = prog32_i ? cpsr_merge : (cpsr_merge & NARROW_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpsr_q     <= RESET_WORD;
      chg_q      <= 1'b0;
      old_bank_q <= BANK_SVC;
      new_bank_q <= BANK_SVC;
    end else begin
      chg_q <= cpsr_wr && (cpsr_next[MODE_W-1:0] != cpsr_q[MODE_W-1:0]);
      if (cpsr_wr) begin
        cpsr_q     <= cpsr_next;
        old_bank_q <= cur_bank;
        new_bank_q <= next_bank;
      end
    end
  end

  psr_saved_bank #(.DEPTH(N_SAVED)) u_saved (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (saved_wr),
    .wr_bank_i    (cur_bank),
    .wr_mask_i    (saved_mask),
    .wr_data_i    (wr_data_i),
    .rd_bank_i    (qry_bank),
    .rd_fallback_i(cpsr_q),
    .rd_data_o    (saved_o)
  );

  assign status_o     = cpsr_q;
  assign query_bank_o = qry_bank;
  assign priv_xlat_o  = |cpsr_q[1:0];
  assign flag_n_o     = cpsr_q[BIT_N];
  assign flag_z_o     = cpsr_q[BIT_Z];
  assign flag_c_o     = cpsr_q[BIT_C];
  assign flag_v_o     = cpsr_q[BIT_V];
  assign irq_mask_o   = cpsr_q[BIT_I];
  assign fiq_mask_o   = cpsr_q[BIT_F];
  assign mode_chg_o   = chg_q;
  assign old_bank_o   = old_bank_q;
  assign new_bank_o   = new_bank_q;
endmodule

// File: rtl/psr_ctrl_chk.sv
module psr_ctrl_chk
  import psr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog32_i,
  input logic              wr_en_i,
  input logic              wr_saved_i,
  input logic [WORD_W-1:0] status_o,
  input logic              mode_chg_o
);
  logic in_user;
  assign in_user = (status_o[4:0] == 5'd0) || (status_o[4:0] == 5'd16);

  p_user_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_saved_i && in_user) |=> (status_o[27:0] == $past(status_o[27:0])));

  p_saved_keeps_cur_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_saved_i) |=> $stable(status_o));

  p_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_saved_i && !prog32_i) |=> ((status_o & ~NARROW_MASK) == '0));

  p_chg_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> $past(wr_en_i && !wr_saved_i));

  p_chg_diff_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> (status_o[4:0] != $past(status_o[4:0])));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(status_o));
endmodule

bind psr_ctrl psr_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prog32_i  (prog32_i),
  .wr_en_i   (wr_en_i),
  .wr_saved_i(wr_saved_i),
  .status_o  (status_o),
  .mode_chg_o(mode_chg_o)
);

// File: tb/psr_ctrl_test.sv
`timescale 1ns/1ps
module psr_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog32_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        wr_saved_i = 1'b0;
  logic [3:0]  wr_fields_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  query_mode_i = '0;
  logic [31:0] status_o, saved_o;
  logic [2:0]  query_bank_o, old_bank_o, new_bank_o;
  logic priv_xlat_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;
  logic irq_mask_o, fiq_mask_o, mode_chg_o;

  int total = 0;
  int fails = 0;

  logic [31:0] m_cpsr;
  logic [31:0] m_saved [0:7];
  bit          m_chg;
  int          m_old, m_new;

  always #10 clk_i = ~clk_i;

  psr_ctrl uut (.*);

  function automatic int bank_of(input int m);
    if (m < 4) return m;
    if (m >= 16 && m < 20) return m - 16;
    if (m == 23) return 4;
    if (m == 27) return 5;
    return 6;
  endfunction

  function automatic logic [31:0] fmask(input bit user, input logic [3:0] f);
    if (user) return f[3] ? 32'hF000_0000 : 32'h0;
    if (f == 4'b1001) return 32'hFFFF_FFFF;
    if (f[0]) return 32'h0000_00DF;
    if (f[3]) return 32'hF000_0000;
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int qb;
    qb = bank_of(int'(query_mode_i));
    chk(status_o, m_cpsr, tag);
    chk({29'd0, query_bank_o}, qb, "R5 query bank");
    if (qb >= 1 && qb <= 5) chk(saved_o, m_saved[qb], "R7 saved read");
    else                    chk(saved_o, m_cpsr, "R6 saved fallback");
    chk({31'd0, priv_xlat_o}, {31'd0, (m_cpsr[1:0] != 2'b00)}, "R9 translation");
    chk({26'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o, irq_mask_o, fiq_mask_o},
        {26'd0, m_cpsr[31:28], m_cpsr[7:6]}, "R10 flag outputs");
    chk({31'd0, mode_chg_o}, {31'd0, m_chg}, "R11 mode pulse");
    if (m_chg) begin
      chk({29'd0, old_bank_o}, m_old, "R11 old bank");
      chk({29'd0, new_bank_o}, m_new, "R11 new bank");
    end
  endtask

  task automatic step(input bit we, input bit ws, input logic [3:0] f,
                      input logic [31:0] d, input logic [4:0] q, input string tag);
    int cb;
    logic [31:0] m, nw;
    wr_en_i = we; wr_saved_i = ws; wr_fields_i = f; wr_data_i = d; query_mode_i = q;
    @(posedge clk_i);
    cb = bank_of(int'(m_cpsr[4:0]));
    m_chg = 1'b0;
    if (we && !ws) begin
      m  = fmask(cb == 0, f);
      nw = (m_cpsr & ~m) | (d & m);
      if (!prog32_i) nw = nw & 32'hF000_00C3;
      m_chg = (nw[4:0] != m_cpsr[4:0]);
      m_old = cb;
      m_new = bank_of(int'(nw[4:0]));
      m_cpsr = nw;
    end else if (we && ws && cb >= 1 && cb <= 5) begin
      m = fmask(1'b0, f);
      m_saved[cb] = (m_saved[cb] & ~m) | (d & m);
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    wr_en_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    m_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 8; i++) m_saved[i] = '0;
    m_chg = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 reset state");
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    chk(status_o, 32'h0000_00D3, "R1 reset word");

    // privileged field rules
    step(1, 0, 4'b0001, 32'hFFFF_FF12, 5'd18, "R4 control field");
    step(1, 0, 4'b1000, 32'hA000_0000, 5'd18, "R4 flag field");
    step(1, 0, 4'b0000, 32'hFFFF_FFFF, 5'd18, "R4 no field");
    step(1, 0, 4'b1011, 32'h5000_0013, 5'd18, "R4 control beats flags");
    step(1, 0, 4'b0001, 32'h0000_0012, 5'd18, "R4 back to irq");
    step(1, 1, 4'b1001, 32'h1234_5678, 5'd18, "R7 saved write irq");
    step(0, 0, 4'b0000, 32'h0, 5'd0, "R6 user query");
    step(0, 0, 4'b0000, 32'h0, 5'd5, "R6 invalid query");
    step(1, 0, 4'b1001, 32'h5000_0011, 5'd17, "R3 full word to fiq");
    step(1, 1, 4'b0001, 32'hFFFF_FFC3, 5'd17, "R7 saved control fiq");
    step(1, 1, 4'b1000, 32'hFFFF_FFFF, 5'd17, "R7 saved flags fiq");
    step(0, 0, 4'b0000, 32'h0, 5'd18, "R7 irq saved kept");
    for (int i = 0; i < 32; i++) step(0, 0, 4'b1001, 32'hFFFF_FFFF, 5'(i), "R12 idle sweep R5");
    step(1, 0, 4'b1001, 32'h9000_001B, 5'd27, "R3 to undefined");
    step(1, 1, 4'b1001, 32'hCAFE_0001, 5'd27, "R7 saved undefined");
    step(1, 0, 4'b1001, 32'h3000_0017, 5'd23, "R3 to abort");
    step(1, 1, 4'b1001, 32'hBEEF_0002, 5'd23, "R7 saved abort");
    step(1, 0, 4'b1001, 32'h0000_001A, 5'd26, "R3 to invalid mode");
    step(1, 1, 4'b1001, 32'h7777_7777, 5'd27, "R6 saved write ignored");
    step(0, 0, 4'b0000, 32'h0, 5'd23, "R6 abort saved kept");
    step(1, 0, 4'b1001, 32'h0000_001A, 5'd26, "R11 same mode no pulse");
    step(1, 0, 4'b1001, 32'h0000_0010, 5'd16, "R3 to user");
    step(1, 0, 4'b1001, 32'hFFFF_FFFF, 5'd16, "R2 user full pattern");
    step(1, 0, 4'b0001, 32'hFFFF_FF13, 5'd16, "R2 user control ignored");
    step(1, 0, 4'b1000, 32'h0000_0000, 5'd16, "R2 user flags");
    step(1, 0, 4'b0000, 32'hF000_0000, 5'd16, "R2 user no field");
    step(1, 1, 4'b1001, 32'h1111_1111, 5'd19, "R6 user saved ignored");

    do_reset();
    prog32_i = 1'b0;
    step(1, 0, 4'b1001, 32'hFFFF_FFFF, 5'd3, "R8 narrow full write");
    step(1, 0, 4'b0001, 32'h0000_0011, 5'd1, "R8 narrow mode");
    step(1, 0, 4'b1000, 32'h5000_0000, 5'd1, "R8 narrow flags");
    prog32_i = 1'b1;

    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [4:0] md;
      bit we;
      case ($urandom_range(0, 5))
        0: md = 5'd17; 1: md = 5'd18; 2: md = 5'd19;
        3: md = 5'd23; 4: md = 5'd27; default: md = 5'($urandom);
      endcase
      we = ($urandom_range(0, 3) != 0);
      if (i % 50 == 49) prog32_i = ~prog32_i;
      if (m_cpsr[4:0] == 5'd16 || m_cpsr[4:0] == 5'd0) begin
        prog32_i = 1'b1;
        do_reset();
      end
      step(we, 1'($urandom), 4'($urandom),
           {$urandom} & 32'hFFFF_FFE0 | {27'd0, md}, 5'($urandom),
           we ? "R3 random write" : "R12 random idle");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule